// File: doc/BRIEF.md
# Register-Mapped Input Controller with Cycle-Stealing Copy

This block is a peripheral that a processor reaches through ordinary loads and stores to a small register window. Software first sets a word count and a destination address, then writes a command word that starts an input transfer. While the transfer runs, the controller collects words from a device-side valid/data stream into a local buffer of up to sixteen words. A busy register and a status register tell software when the transfer has ended and whether the device reported a fault.

The command word selects one of three ways to end the transfer. In polled mode, software watches the busy register and then reads the buffer words through the register window. In interrupt mode, the controller also raises an interrupt line when the transfer ends. In copy mode, the controller becomes a bus master after the buffer is full. It writes the buffer into main memory one word per granted bus cycle, then drops busy and raises the interrupt. A device error flag ends any transfer early.

Top module: `devctl_dma`

## Requirements
- R1: After reset, busy (offset 0x0C, bit 0) reads 0, status (offset 0x10) reads 0, the length register (offset 0x04) reads 0, and both irq and memReq are low.
- R2: A write to offset 0x00 starts a transfer and sets busy in the next cycle, but only if bits 1:0 are 1 (polled), 2 (interrupt) or 3 (copy) and the stored length is 1 to 16. A length write above 16 is stored as 0. A command value of 0, or a stored length of 0, leaves the block idle.
- R3: While busy is 1, writes to the command, length and destination registers are ignored. The length and destination read back unchanged, and the running transfer keeps its mode.
- R4: Each cycle with devValid high during a transfer stores devData in the next buffer word. Word i reads back at offset 0x40 + 4*i.
- R5: In polled mode, busy clears in the cycle after the last word is captured, the status done bit (bit 0) becomes 1, and irq stays low.
- R6: In interrupt mode, irq goes high in the same cycle that busy clears at the end of a transfer.
- R7: In copy mode, after the last word is captured, memReq is held with memAddr = destination + 4*i and memData = buffer word i. Each cycle with memGnt high advances i. After the final granted write, memReq falls, busy clears, done is set, and irq rises.
- R8: While memReq is high and memGnt is low, memAddr and memData hold their values.
- R9: A read of status returns the done bit (bit 0) and the error bit (bit 1). The read then clears done and drops irq. The error bit stays set until the next accepted start, which clears both bits.
- R10: devErr high during a transfer ends it in the next cycle. busy clears, status becomes 3, irq rises in interrupt or copy mode, and no further memory writes are issued.
- R11: devValid has no effect while the block is idle, so buffer contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register window byte offset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe (clears status on a status read) |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data, combinational from busAddr |
| devValid | input | 1 | Device word valid |
| devData | input | 32 | Device word |
| devErr | input | 1 | Device fault flag |
| memReq | output | 1 | Memory write request |
| memAddr | output | 32 | Memory write byte address |
| memData | output | 32 | Memory write data |
| memGnt | input | 1 | Arbiter grant; a write completes in a cycle where memReq and memGnt are both high |
| irq | output | 1 | Interrupt to the processor |

## Verification
The assertions assume that memGnt only matters while memReq is high, and that devErr is a single-cycle pulse raised only while a transfer is running. The stimulus drives devErr only in those windows. It toggles memGnt freely, including long stretches with no grant. Bus accesses are applied one at a time and are held for exactly one cycle, so a status read and a command write never meet in the same cycle.

// File: rtl/devctl_pkg.sv
package devctl_pkg;

  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] OFF_CMD  = 8'h00;
  localparam logic [REG_AW-1:0] OFF_LEN  = 8'h04;
  localparam logic [REG_AW-1:0] OFF_DEST = 8'h08;
  localparam logic [REG_AW-1:0] OFF_BUSY = 8'h0C;
  localparam logic [REG_AW-1:0] OFF_STAT = 8'h10;
  localparam logic [REG_AW-1:0] OFF_BUF  = 8'h40;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_POLL = 2'd1,
    MODE_IRQ  = 2'd2,
    MODE_COPY = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_COPY = 2'd2
  } state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;     // accepted command: clear status
    logic capture;   // store devData at fill index
    logic finish;    // normal end of transfer
    logic abort;     // device fault end of transfer
    logic irqOnEnd;  // raise irq on finish/abort
  } strobes_t;

endpackage

// File: rtl/devctl_ctrl.sv
module devctl_ctrl
  import devctl_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int LEN_W     = $clog2(BUF_DEPTH + 1),
  parameter int IDX_W     = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWr,
  input  logic [1:0]       cmdMode,
  input  logic [LEN_W-1:0] lenCfg,
  input  logic             devValid,
  input  logic             devErr,
  input  logic             memGnt,
  output strobes_t         stb,
  output logic             busy,
  output logic             memReq,
  output logic [IDX_W-1:0] fillIdx,
  output logic [IDX_W-1:0] copyIdx
);

  state_e           state;
  mode_e            modeLat;
  logic [LEN_W-1:0] lenLat;
  logic             accept;
  logic             fillLast;
  logic             copyLast;

  assign fillLast = (LEN_W'(fillIdx) + 1'b1) == lenLat;
  assign copyLast = (LEN_W'(copyIdx) + 1'b1) == lenLat;

  assign accept = cmdWr && (state == ST_IDLE) && (cmdMode != 2'd0) &&
                  (lenCfg != '0) && (lenCfg <= LEN_W'(BUF_DEPTH));

  assign busy   = (state != ST_IDLE);
  assign memReq = (state == ST_COPY);

  always_comb begin
    stb          = '0;
    stb.start    = accept;
    stb.irqOnEnd = (modeLat != MODE_POLL);
    case (state)
      ST_FILL: begin
        if (devErr) begin
          stb.abort = 1'b1;
        end else if (devValid) begin
          stb.capture = 1'b1;
          if (fillLast && modeLat != MODE_COPY) stb.finish = 1'b1;
        end
      end
      ST_COPY: begin
        if (devErr) stb.abort = 1'b1;
        else if (memGnt && copyLast) stb.finish = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      modeLat <= MODE_NONE;
      lenLat  <= '0;
      fillIdx <= '0;
      copyIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_FILL;
            modeLat <= mode_e'(cmdMode);
            lenLat  <= lenCfg;
            fillIdx <= '0;
            copyIdx <= '0;
          end
        end
        ST_FILL: begin
          if (devErr) begin
            state <= ST_IDLE;
          end else if (devValid) begin
            fillIdx <= fillIdx + 1'b1;
            if (fillLast) state <= (modeLat == MODE_COPY) ? ST_COPY : ST_IDLE;
          end
        end
        ST_COPY: begin
          if (devErr) begin
            state <= ST_IDLE;
          end else if (memGnt) begin
            copyIdx <= copyIdx + 1'b1;
            if (copyLast) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/devctl_dp.sv
module devctl_dp
  import devctl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_DEPTH = 16,
  parameter int LEN_W     = $clog2(BUF_DEPTH + 1),
  parameter int IDX_W     = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] devData,
  input  strobes_t          stb,
  input  logic              busy,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [IDX_W-1:0]  copyIdx,
  output logic              cmdWr,
  output logic [1:0]        cmdMode,
  output logic [LEN_W-1:0]  lenCfg,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              irq
);

  localparam logic [REG_AW-1:0] BUF_END = OFF_BUF + REG_AW'(4 * BUF_DEPTH);

  logic [DATA_W-1:0] bufMem [BUF_DEPTH];
  logic [DATA_W-1:0] destReg;
  logic [LEN_W-1:0]  lenReg;
  logic              doneBit;
  logic              errBit;
  logic              irqReg;
  logic              statRead;
  logic [REG_AW-1:0] bufOff;
  logic [IDX_W-1:0]  bufSel;

  assign cmdWr    = busWe && (busAddr == OFF_CMD);
  assign cmdMode  = busWdata[1:0];
  assign lenCfg   = lenReg;
  assign statRead = busRe && (busAddr == OFF_STAT);
  assign irq      = irqReg;

  assign bufOff = busAddr - OFF_BUF;
  assign bufSel = bufOff[IDX_W+1:2];

  assign memAddr = destReg + (DATA_W'(copyIdx) << 2);
  assign memData = bufMem[copyIdx];

  // Configuration registers: frozen while busy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg  <= '0;
      destReg <= '0;
    end else if (busWe && !busy) begin
      if (busAddr == OFF_LEN)
        lenReg <= (busWdata > DATA_W'(BUF_DEPTH)) ? '0 : busWdata[LEN_W-1:0];
      if (busAddr == OFF_DEST)
        destReg <= busWdata;
    end
  end

  // Capture buffer, one write port per slot
  for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (stb.capture && fillIdx == IDX_W'(g)) bufMem[g] <= devData;
    end
  end

  // Status and interrupt
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneBit <= 1'b0;
      errBit  <= 1'b0;
      irqReg  <= 1'b0;
    end else if (stb.start) begin
      doneBit <= 1'b0;
      errBit  <= 1'b0;
      irqReg  <= 1'b0;
    end else if (stb.finish || stb.abort) begin
      doneBit <= 1'b1;
      errBit  <= errBit | stb.abort;
      irqReg  <= stb.irqOnEnd;
    end else if (statRead) begin
      doneBit <= 1'b0;
      irqReg  <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr >= OFF_BUF && busAddr < BUF_END) begin
      busRdata = bufMem[bufSel];
    end else begin
      case (busAddr)
        OFF_LEN:  busRdata = DATA_W'(lenReg);
        OFF_DEST: busRdata = destReg;
        OFF_BUSY: busRdata = DATA_W'(busy);
        OFF_STAT: busRdata = DATA_W'({errBit, doneBit});
        default:  busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/devctl_dma.sv
module devctl_dma
  import devctl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              devValid,
  input  logic [DATA_W-1:0] devData,
  input  logic              devErr,
  output logic              memReq,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  input  logic              memGnt,
  output logic              irq
);

  localparam int LEN_W = $clog2(BUF_DEPTH + 1);
  localparam int IDX_W = $clog2(BUF_DEPTH);

  strobes_t         stb;
  logic             busyFlag;
  logic             cmdWr;
  logic [1:0]       cmdMode;
  logic [LEN_W-1:0] lenCfg;
  logic [IDX_W-1:0] fillIdx;
  logic [IDX_W-1:0] copyIdx;

  devctl_ctrl #(.BUF_DEPTH(BUF_DEPTH), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWr    (cmdWr),
    .cmdMode  (cmdMode),
    .lenCfg   (lenCfg),
    .devValid (devValid),
    .devErr   (devErr),
    .memGnt   (memGnt),
    .stb      (stb),
    .busy     (busyFlag),
    .memReq   (memReq),
    .fillIdx  (fillIdx),
    .copyIdx  (copyIdx)
  );

  devctl_dp #(.DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busRe    (busRe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .devData  (devData),
    .stb      (stb),
    .busy     (busyFlag),
    .fillIdx  (fillIdx),
    .copyIdx  (copyIdx),
    .cmdWr    (cmdWr),
    .cmdMode  (cmdMode),
    .lenCfg   (lenCfg),
    .memAddr  (memAddr),
    .memData  (memData),
    .irq      (irq)
  );

endmodule

// File: rtl/devctl_sva.sv
module devctl_sva #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memReq,
  input logic              memGnt,
  input logic              devErr,
  input logic              irq,
  input logic              busRe,
  input logic [7:0]        busAddr,
  input logic [DATA_W-1:0] memAddr,
  input logic [DATA_W-1:0] memData
);

  // R7: memory requests only inside a running transfer
  p_req_in_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R7: a granted write moves to the next word address
  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memGnt && !devErr) |=> (!memReq || memAddr == $past(memAddr) + DATA_W'(4)));

  // R8: request held stable while not granted
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt && !devErr) |=> (memReq && $stable(memAddr) && $stable(memData)));

  // R6: interrupt only ever seen with busy low
  p_irq_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !busy);

  // R10: device fault ends the transfer and the copy at once
  p_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && devErr) |=> (!busy && !memReq));

  // R9: status read while idle drops the interrupt
  p_stat_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == 8'h10 && !busy) |=> !irq);

endmodule

bind devctl_dma devctl_sva #(.DATA_W(DATA_W)) u_sva (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busyFlag),
  .memReq  (memReq),
  .memGnt  (memGnt),
  .devErr  (devErr),
  .irq     (irq),
  .busRe   (busRe),
  .busAddr (busAddr),
  .memAddr (memAddr),
  .memData (memData)
);

// File: tb/tb_devctl_dma.sv
`timescale 1ns/1ps
module tb_devctl_dma;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        devValid = 1'b0;
  logic [31:0] devData = '0;
  logic        devErr = 1'b0;
  logic        memReq;
  logic [31:0] memAddr;
  logic [31:0] memData;
  logic        memGnt = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [31:0] capAddr [64];
  logic [31:0] capData [64];
  int wrCount = 0;

  always #2.5 clk = ~clk;

  devctl_dma dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .devValid(devValid), .devData(devData),
    .devErr(devErr), .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .memGnt(memGnt), .irq(irq)
  );

  // Memory side monitor
  always @(posedge clk) begin
    if (rstN && memReq && memGnt) begin
      if (wrCount < 64) begin
        capAddr[wrCount] = memAddr;
        capData[wrCount] = memData;
      end
      wrCount = wrCount + 1;
    end
  end

  typedef struct packed {
    logic [1:0]  mode;
    logic [4:0]  len;
    logic [31:0] dest;
    logic [31:0] seed;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{2'd1, 5'd1,  32'h0000_2000, 32'hA000_0000},
    '{2'd2, 5'd5,  32'h0000_3000, 32'hB000_0010},
    '{2'd3, 5'd16, 32'h0000_4000, 32'hC000_0100},
    '{2'd3, 5'd3,  32'h0000_5000, 32'hD000_1000}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic feed(input int n, input logic [31:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      devValid = 1'b1; devData = seed + 32'(i);
    end
    @(negedge clk);
    devValid = 1'b0;
  endtask

  task automatic pulseErr();
    @(negedge clk);
    devErr = 1'b1;
    @(negedge clk);
    devErr = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
    if (!finished) $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] keep;
    int base;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
    chk(memReq == 1'b0, "R1 memReq", 32'(memReq), 0);
    rd(8'h0C, v); chk(v == 0, "R1 busy", v, 0);
    rd(8'h10, v); chk(v == 0, "R1 status", v, 0);
    rd(8'h04, v); chk(v == 0, "R1 length", v, 0);

    // R2 command 0 ignored
    wr(8'h04, 32'd4);
    wr(8'h00, 32'd0);
    rd(8'h0C, v); chk(v == 0, "R2 mode0 busy", v, 0);
    // R2 length above 16 stored as 0 and start refused
    wr(8'h04, 32'd17);
    rd(8'h04, v); chk(v == 0, "R2 len17 readback", v, 0);
    wr(8'h00, 32'd1);
    rd(8'h0C, v); chk(v == 0, "R2 len17 busy", v, 0);

    // Table of transfers
    for (int t = 0; t < 4; t++) begin
      vec_t c;
      c = VECS[t];
      base = wrCount;
      wr(8'h04, 32'(c.len));
      wr(8'h08, c.dest);
      wr(8'h00, 32'(c.mode));
      rd(8'h0C, v); chk(v == 1, "R2 busy after start", v, 1);
      feed(int'(c.len), c.seed);
      if (c.mode != 2'd3) begin
        chk(memReq == 1'b0, "R5 no memReq", 32'(memReq), 0);
        chk(irq == (c.mode == 2'd2), c.mode == 2'd2 ? "R6 irq at end" : "R5 irq low",
            32'(irq), 32'(c.mode == 2'd2));
      end else begin
        chk(memReq == 1'b1, "R7 memReq after fill", 32'(memReq), 1);
        for (int k = 0; k < 400 && memReq; k++) begin
          @(negedge clk);
          memGnt = (k % 3 != 0);
        end
        @(negedge clk);
        memGnt = 1'b0;
        chk(irq == 1'b1, "R7 irq after copy", 32'(irq), 1);
        chk(wrCount - base == int'(c.len), "R7 write count", 32'(wrCount - base), 32'(c.len));
        for (int i = 0; i < int'(c.len); i++) begin
          chk(capAddr[base+i] == c.dest + 32'(4*i), "R7 address", capAddr[base+i], c.dest + 32'(4*i));
          chk(capData[base+i] == c.seed + 32'(i), "R7 data", capData[base+i], c.seed + 32'(i));
        end
      end
      rd(8'h0C, v); chk(v == 0, "R5 busy cleared", v, 0);
      rd(8'h10, v); chk(v == 1, "R9 status done", v, 1);
      chk(irq == 1'b0, "R9 irq cleared by read", 32'(irq), 0);
      rd(8'h10, v); chk(v == 0, "R9 done cleared", v, 0);
      for (int i = 0; i < int'(c.len); i++) begin
        rd(8'h40 + 8'(4*i), v);
        chk(v == c.seed + 32'(i), "R4 buffer word", v, c.seed + 32'(i));
      end
    end

    // R3 writes ignored while busy
    wr(8'h04, 32'd2);
    wr(8'h08, 32'h100);
    wr(8'h00, 32'd1);
    wr(8'h04, 32'd7);
    wr(8'h08, 32'h200);
    wr(8'h00, 32'd3);
    rd(8'h04, v); chk(v == 2, "R3 length frozen", v, 2);
    rd(8'h08, v); chk(v == 32'h100, "R3 dest frozen", v, 32'h100);
    feed(2, 32'h5500_0000);
    chk(memReq == 1'b0, "R3 mode kept polled", 32'(memReq), 0);
    chk(irq == 1'b0, "R3 no irq", 32'(irq), 0);
    rd(8'h0C, v); chk(v == 0, "R3 done after 2 words", v, 0);
    rd(8'h10, v);

    // R11 devValid while idle ignored
    rd(8'h40, keep);
    feed(3, 32'hDEAD_0000);
    rd(8'h40, v); chk(v == keep, "R11 idle capture", v, keep);
    rd(8'h44, v); chk(v == 32'h5500_0001, "R11 idle word1", v, 32'h5500_0001);

    // R10 abort in interrupt mode
    wr(8'h04, 32'd4);
    wr(8'h00, 32'd2);
    feed(2, 32'h7700_0000);
    pulseErr();
    chk(irq == 1'b1, "R10 irq on abort", 32'(irq), 1);
    rd(8'h0C, v); chk(v == 0, "R10 busy cleared", v, 0);
    rd(8'h10, v); chk(v == 3, "R10 status", v, 3);
    rd(8'h10, v); chk(v == 2, "R9 error persists", v, 2);
    chk(irq == 1'b0, "R9 irq low", 32'(irq), 0);

    // R8 hold and R10 abort in copy mode
    wr(8'h04, 32'd4);
    wr(8'h08, 32'h1000);
    wr(8'h00, 32'd3);
    rd(8'h10, v); chk(v == 0, "R9 start clears error", v, 0);
    feed(4, 32'h9900_0000);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(memReq == 1'b1 && memAddr == 32'h1000 && memData == 32'h9900_0000,
          "R8 hold without grant", memAddr, 32'h1000);
    end
    base = wrCount;
    @(negedge clk); memGnt = 1'b1;
    @(negedge clk); memGnt = 1'b0;
    chk(memAddr == 32'h1004, "R7 advance on grant", memAddr, 32'h1004);
    pulseErr();
    chk(memReq == 1'b0, "R10 copy stopped", 32'(memReq), 0);
    chk(irq == 1'b1, "R10 copy irq", 32'(irq), 1);
    @(negedge clk); memGnt = 1'b1;
    repeat (3) @(negedge clk);
    memGnt = 1'b0;
    chk(wrCount - base == 1, "R10 no further writes", 32'(wrCount - base), 1);
    rd(8'h10, v); chk(v == 3, "R10 copy status", v, 3);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule